// File: doc/BRIEF.md
# Register Rename Table with Move Elimination

This block is the alias table of a single-issue rename stage. It holds, for every architectural register, the tag of the physical register that currently carries its value. Each accepted operation is one of three kinds: a two-source ALU operation with one destination, a register-to-register move, or an exchange of two architectural registers. For each one the block returns the physical tags of both sources, the physical tag that the destination now names, the tag the destination named before, and a flag that says whether a micro-op has to be sent to execution.

Moves and exchanges need no execution slot. A move with elimination turned on points the destination at the source's physical register, so two or more architectural registers can share one physical register. An exchange swaps two table entries. A reference count per physical register records how many table entries point at it. A physical register goes back to the free pool only when its count is zero and a later stage asks for it through the release port. When an operation needs a new register and none is free, the block holds its input not-ready.

Top module: `rat_rename`

## Requirements
- R1: After reset, architectural register i maps to physical register i. Physical registers NARCH to NPHYS-1 are free, and a new register is always taken from the lowest-numbered free index.
- R2: Both source tags are read from the table as it stood before the same operation's destination update. An operation whose source and destination are the same register reports the old tag.
- R3: An ALU operation (in_op 2'b00, and 2'b11, which is treated the same way) takes the lowest free physical register, points its destination at it, reports it on out_pdst with out_issue=1, and reports the former mapping on out_pold with out_pold_valid=1.
- R4: A move (in_op 2'b01, source in_src_a) with elim_en=1 and distinct registers points the destination at the source's physical register, reports that tag on out_pdst, allocates nothing, and gives out_issue=0 and out_pold_valid=1.
- R5: A move with elim_en=0 allocates like R3, issues a copy (out_issue=1), and reports the source's physical tag on out_psrc_a.
- R6: After an eliminated move, the source and destination registers both translate to the same physical register. The sum of all reference counts always equals NARCH.
- R7: An exchange (in_op 2'b10) swaps the entries of in_dst and in_src_a. It reports the new destination tag, allocates nothing, and gives out_issue=0 and out_pold_valid=0.
- R8: in_ready is low exactly when in_valid is high, the operation needs a new register, and no register is free. Operations that need no new register are still accepted while the pool is empty.
- R9: A release of a physical register returns it to the pool only if its reference count is zero. A release of a register that is still mapped, or that is already free, has no effect.
- R10: A move with elim_en=1 whose source and destination are the same register changes no entry and no count. It reports that register's own tag with out_issue=0 and out_pold_valid=0.
- R11: The results of an operation accepted at a clock edge appear with out_valid=1 during the following cycle. out_valid is 0 in every other cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operation present |
| in_ready | output | 1 | Operation can be accepted this cycle |
| in_op | input | 2 | 00 ALU, 01 move, 10 exchange, 11 ALU |
| in_src_a | input | $clog2(NARCH) | First source; move source; exchange partner |
| in_src_b | input | $clog2(NARCH) | Second source |
| in_dst | input | $clog2(NARCH) | Destination register |
| elim_en | input | 1 | Enables move elimination |
| rel_valid | input | 1 | Release request |
| rel_tag | input | $clog2(NPHYS) | Physical register to release |
| out_valid | output | 1 | Results of last accepted operation |
| out_issue | output | 1 | A micro-op must be issued |
| out_psrc_a | output | $clog2(NPHYS) | Physical tag of first source |
| out_psrc_b | output | $clog2(NPHYS) | Physical tag of second source |
| out_pdst | output | $clog2(NPHYS) | New physical tag of the destination |
| out_pold | output | $clog2(NPHYS) | Prior physical tag of the destination |
| out_pold_valid | output | 1 | out_pold names a dropped reference |

## Verification
The hardest state to reach is an empty pool with physical registers whose count has fallen to zero but which have not yet been released. Only in that state do a stall, a release that is ignored and a release that is honoured all show at the ports. The stimulus runs ALU operations until the reference model's pool is empty. It then checks that an allocating operation stalls while an exchange still passes. It releases a register that is still mapped and confirms the stall remains. It then releases a zero-count register and expects the next operation to receive exactly that tag.

// File: rtl/rat_pkg.sv
package rat_pkg;
  typedef enum logic [1:0] {
    OP_ALU  = 2'b00,
    OP_MOVE = 2'b01,
    OP_SWAP = 2'b10,
    OP_ALT  = 2'b11
  } rn_op_e;
endpackage

// File: rtl/rat_freelist.sv
module rat_freelist #(
  parameter int NARCH = 16,
  parameter int NPHYS = 64,
  localparam int PW = $clog2(NPHYS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             take_en,
  input  logic             rel_valid,
  input  logic [PW-1:0]    rel_tag,
  input  logic [NPHYS-1:0] cnt_zero,
  output logic [NPHYS-1:0] free_vec,
  output logic             any_free,
  output logic [PW-1:0]    pick_tag
);
  function automatic logic [PW-1:0] lowest_set(input logic [NPHYS-1:0] v);
    logic [PW-1:0] r;
    r = '0;
    for (int i = NPHYS - 1; i >= 0; i--) begin
      if (v[i]) r = PW'(i);
    end
    return r;
  endfunction

  logic [NPHYS-1:0] free_q;

  assign free_vec = free_q;
  assign any_free = |free_q;
  assign pick_tag = lowest_set(free_q);

  for (genvar p = 0; p < NPHYS; p++) begin : g_slot
    logic hit_rel, hit_take;
    assign hit_rel  = rel_valid && (rel_tag == PW'(p)) && cnt_zero[p];
    assign hit_take = take_en && (pick_tag == PW'(p));
    always_ff @(posedge clk) begin
      if (!rst_n)        free_q[p] <= (p >= NARCH);
      else if (hit_take) free_q[p] <= 1'b0;
      else if (hit_rel)  free_q[p] <= 1'b1;
    end
  end
endmodule

// File: rtl/rat_refcnt.sv
module rat_refcnt #(
  parameter int NARCH = 16,
  parameter int NPHYS = 64,
  localparam int PW = $clog2(NPHYS),
  localparam int CW = $clog2(NARCH + 1)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                set_en,
  input  logic [PW-1:0]       set_tag,
  input  logic                inc_en,
  input  logic [PW-1:0]       inc_tag,
  input  logic                dec_en,
  input  logic [PW-1:0]       dec_tag,
  output logic [NPHYS-1:0]    cnt_zero,
  output logic [NPHYS*CW-1:0] cnt_flat
);
  function automatic logic [CW-1:0] step_count(input logic [CW-1:0] cur,
                                               input logic inc, input logic dec);
    return CW'(cur + CW'(inc) - CW'(dec));
  endfunction

  for (genvar p = 0; p < NPHYS; p++) begin : g_cnt
    logic [CW-1:0] cnt_q;
    logic          up, down, seed;
    assign seed = set_en && (set_tag == PW'(p));
    assign up   = inc_en && (inc_tag == PW'(p));
    assign down = dec_en && (dec_tag == PW'(p));
    always_ff @(posedge clk) begin
      if (!rst_n)    cnt_q <= (p < NARCH) ? CW'(1) : '0;
      else if (seed) cnt_q <= CW'(1);
      else           cnt_q <= step_count(cnt_q, up, down);
    end
    assign cnt_zero[p] = (cnt_q == '0);
    assign cnt_flat[p*CW +: CW] = cnt_q;
  end
endmodule

// File: rtl/rat_rename.sv
module rat_rename
  import rat_pkg::*;
#(
  parameter int NARCH = 16,
  parameter int NPHYS = 64,
  localparam int AW = $clog2(NARCH),
  localparam int PW = $clog2(NPHYS),
  localparam int CW = $clog2(NARCH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [1:0]    in_op,
  input  logic [AW-1:0] in_src_a,
  input  logic [AW-1:0] in_src_b,
  input  logic [AW-1:0] in_dst,
  input  logic          elim_en,
  input  logic          rel_valid,
  input  logic [PW-1:0] rel_tag,
  output logic          out_valid,
  output logic          out_issue,
  output logic [PW-1:0] out_psrc_a,
  output logic [PW-1:0] out_psrc_b,
  output logic [PW-1:0] out_pdst,
  output logic [PW-1:0] out_pold,
  output logic          out_pold_valid
);
  logic [PW-1:0] map_q [NARCH];
  logic [PW-1:0] ps_a, ps_b, pd_old, alloc_tag;
  logic [NPHYS-1:0] free_vec, cnt_zero;
  logic [NPHYS*CW-1:0] cnt_flat;
  logic [NARCH*PW-1:0] map_flat;
  logic fl_any;
  rn_op_e op;

  // Named decode and event wires, also observed by the checker.
  logic is_move, is_swap, need_alloc, mov_elim, self_mov;
  logic accept, alloc_fire, share_fire, swap_fire;

  assign op         = rn_op_e'(in_op);
  assign ps_a       = map_q[in_src_a];
  assign ps_b       = map_q[in_src_b];
  assign pd_old     = map_q[in_dst];
  assign is_move    = (op == OP_MOVE);
  assign is_swap    = (op == OP_SWAP);
  assign need_alloc = !is_swap && !(is_move && elim_en);
  assign mov_elim   = is_move && elim_en;
  assign self_mov   = mov_elim && (in_src_a == in_dst);
  assign in_ready   = !(in_valid && need_alloc && !fl_any);
  assign accept     = in_valid && in_ready;
  assign alloc_fire = accept && need_alloc;
  assign share_fire = accept && mov_elim && !self_mov;
  assign swap_fire  = accept && is_swap;

  rat_freelist #(.NARCH(NARCH), .NPHYS(NPHYS)) u_free (
    .clk(clk), .rst_n(rst_n),
    .take_en(alloc_fire),
    .rel_valid(rel_valid), .rel_tag(rel_tag),
    .cnt_zero(cnt_zero),
    .free_vec(free_vec), .any_free(fl_any), .pick_tag(alloc_tag)
  );

  rat_refcnt #(.NARCH(NARCH), .NPHYS(NPHYS)) u_cnt (
    .clk(clk), .rst_n(rst_n),
    .set_en(alloc_fire), .set_tag(alloc_tag),
    .inc_en(share_fire), .inc_tag(ps_a),
    .dec_en(alloc_fire || share_fire), .dec_tag(pd_old),
    .cnt_zero(cnt_zero), .cnt_flat(cnt_flat)
  );

  for (genvar r = 0; r < NARCH; r++) begin : g_map
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        map_q[r] <= PW'(r);
      end else if (alloc_fire && in_dst == AW'(r)) begin
        map_q[r] <= alloc_tag;
      end else if ((share_fire || swap_fire) && in_dst == AW'(r)) begin
        map_q[r] <= ps_a;
      end else if (swap_fire && in_src_a == AW'(r)) begin
        map_q[r] <= pd_old;
      end
    end
    assign map_flat[r*PW +: PW] = map_q[r];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid      <= 1'b0;
      out_issue      <= 1'b0;
      out_psrc_a     <= '0;
      out_psrc_b     <= '0;
      out_pdst       <= '0;
      out_pold       <= '0;
      out_pold_valid <= 1'b0;
    end else begin
      out_valid <= accept;
      if (accept) begin
        out_issue      <= need_alloc;
        out_psrc_a     <= ps_a;
        out_psrc_b     <= ps_b;
        out_pdst       <= need_alloc ? alloc_tag : ps_a;
        out_pold       <= pd_old;
        out_pold_valid <= alloc_fire || share_fire;
      end
    end
  end
endmodule

// File: rtl/rat_rename_chk.sv
module rat_rename_chk #(
  parameter int NARCH = 16,
  parameter int NPHYS = 64,
  localparam int AW = $clog2(NARCH),
  localparam int PW = $clog2(NPHYS),
  localparam int CW = $clog2(NARCH + 1)
) (
  input logic                clk,
  input logic                rst_n,
  input logic                in_valid,
  input logic                in_ready,
  input logic                accept,
  input logic                alloc_fire,
  input logic                share_fire,
  input logic                swap_fire,
  input logic                fl_any,
  input logic                rel_valid,
  input logic [AW-1:0]       in_src_a,
  input logic [AW-1:0]       in_dst,
  input logic [PW-1:0]       alloc_tag,
  input logic [NPHYS-1:0]    free_vec,
  input logic [NPHYS*CW-1:0] cnt_flat,
  input logic [NARCH*PW-1:0] map_flat,
  input logic                out_valid
);
  function automatic logic [PW-1:0] map_at(input logic [NARCH*PW-1:0] m,
                                           input logic [AW-1:0] i);
    return m[i*PW +: PW];
  endfunction

  int unsigned ref_sum;
  logic        free_but_held;
  always_comb begin
    ref_sum = 0;
    free_but_held = 1'b0;
    for (int p = 0; p < NPHYS; p++) begin
      ref_sum += int'(cnt_flat[p*CW +: CW]);
      if (free_vec[p] && cnt_flat[p*CW +: CW] != '0) free_but_held = 1'b1;
    end
  end

  p_stall_empty_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !in_ready) |-> !fl_any);
  p_ready_free_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && fl_any) |-> in_ready);
  p_take_free_r3: assert property (@(posedge clk) disable iff (!rst_n)
    alloc_fire |-> free_vec[alloc_tag]);
  p_ref_sum_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ref_sum == NARCH);
  p_free_unref_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !free_but_held);
  p_swap_noalloc_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (swap_fire && !rel_valid) |=> free_vec == $past(free_vec));
  p_share_map_r4: assert property (@(posedge clk) disable iff (!rst_n)
    share_fire |=> map_at(map_flat, $past(in_dst)) == $past(map_at(map_flat, in_src_a)));
  p_out_follow_r11: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> out_valid);
  p_out_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !accept |=> !out_valid);
endmodule

bind rat_rename rat_rename_chk #(.NARCH(NARCH), .NPHYS(NPHYS)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .accept(accept), .alloc_fire(alloc_fire), .share_fire(share_fire),
  .swap_fire(swap_fire), .fl_any(fl_any), .rel_valid(rel_valid),
  .in_src_a(in_src_a), .in_dst(in_dst), .alloc_tag(alloc_tag),
  .free_vec(free_vec), .cnt_flat(cnt_flat), .map_flat(map_flat),
  .out_valid(out_valid)
);

// File: tb/test_rat_rename.sv
module test_rat_rename;
  localparam int NARCH = 16;
  localparam int NPHYS = 64;
  localparam int AW = $clog2(NARCH);
  localparam int PW = $clog2(NPHYS);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0, elim_en = 1'b0, rel_valid = 1'b0;
  logic [1:0] in_op = '0;
  logic [AW-1:0] in_src_a = '0, in_src_b = '0, in_dst = '0;
  logic [PW-1:0] rel_tag = '0;
  logic in_ready, out_valid, out_issue, out_pold_valid;
  logic [PW-1:0] out_psrc_a, out_psrc_b, out_pdst, out_pold;

  always #5 clk = ~clk;

  rat_rename #(.NARCH(NARCH), .NPHYS(NPHYS)) i_rat_rename (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_op(in_op), .in_src_a(in_src_a), .in_src_b(in_src_b), .in_dst(in_dst),
    .elim_en(elim_en), .rel_valid(rel_valid), .rel_tag(rel_tag),
    .out_valid(out_valid), .out_issue(out_issue), .out_psrc_a(out_psrc_a),
    .out_psrc_b(out_psrc_b), .out_pdst(out_pdst), .out_pold(out_pold),
    .out_pold_valid(out_pold_valid)
  );

  typedef struct {
    int psa, psb, pd, pold;
    bit issue, pold_v;
    string req;
  } exp_t;
  exp_t sb[$];

  int checks = 0, errors = 0;
  int m_map[NARCH];
  int m_cnt[NPHYS];
  bit m_free[NPHYS];

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic int model_pick();
    for (int p = 0; p < NPHYS; p++) if (m_free[p]) return p;
    return -1;
  endfunction

  // Scoreboard monitor: compares each result cycle with the oldest expectation.
  always @(negedge clk) begin
    if (rst_n && out_valid) begin
      if (sb.size() == 0) begin
        check(0, "R11", "unexpected out_valid", 1, 0);
      end else begin
        exp_t e;
        e = sb.pop_front();
        check(int'(out_psrc_a) == e.psa, "R2", {e.req, " psrc_a"}, int'(out_psrc_a), e.psa);
        check(int'(out_psrc_b) == e.psb, "R2", {e.req, " psrc_b"}, int'(out_psrc_b), e.psb);
        check(int'(out_pdst) == e.pd, e.req, "pdst", int'(out_pdst), e.pd);
        check(out_issue == e.issue, e.req, "issue", int'(out_issue), int'(e.issue));
        check(out_pold_valid == e.pold_v, e.req, "pold_valid", int'(out_pold_valid), int'(e.pold_v));
        if (e.pold_v) check(int'(out_pold) == e.pold, e.req, "pold", int'(out_pold), e.pold);
      end
    end
  end

  // Driver: presents one operation; returns whether it was accepted.
  task automatic send(input int op, input int a, input int b, input int d,
                      input bit elim, input string req, output bit took);
    int psa, psb, old, t;
    bit need;
    exp_t e;
    @(negedge clk);
    rel_valid = 1'b0;
    in_valid = 1'b1; in_op = 2'(op); in_src_a = AW'(a); in_src_b = AW'(b);
    in_dst = AW'(d); elim_en = elim;
    #1;
    psa = m_map[a]; psb = m_map[b]; old = m_map[d];
    need = (op == 0 || op == 3) || (op == 1 && !elim);
    t = model_pick();
    took = 1'b0;
    if (need && t < 0) begin
      check(in_ready == 1'b0, "R8", "ready while pool empty", int'(in_ready), 0);
      @(posedge clk);
      #1 in_valid = 1'b0;
      return;
    end
    check(in_ready == 1'b1, "R8", "ready", int'(in_ready), 1);
    took = 1'b1;
    e.psa = psa; e.psb = psb; e.pold = old; e.req = req;
    if (need) begin
      m_free[t] = 0; m_cnt[t] = 1; m_cnt[old]--; m_map[d] = t;
      e.pd = t; e.issue = 1; e.pold_v = 1;
    end else if (op == 1) begin
      e.pd = psa; e.issue = 0;
      if (a == d) e.pold_v = 0;
      else begin
        m_cnt[psa]++; m_cnt[old]--; m_map[d] = psa; e.pold_v = 1;
      end
    end else begin
      m_map[d] = psa; m_map[a] = old;
      e.pd = psa; e.issue = 0; e.pold_v = 0;
    end
    sb.push_back(e);
  endtask

  task automatic idle();
    @(negedge clk);
    in_valid = 1'b0; rel_valid = 1'b0;
  endtask

  task automatic release_tag(input int t);
    @(negedge clk);
    in_valid = 1'b0; rel_valid = 1'b1; rel_tag = PW'(t);
    if (m_cnt[t] == 0 && !m_free[t]) m_free[t] = 1;
    @(negedge clk);
    rel_valid = 1'b0;
  endtask

  initial begin
    for (int w = 0; w < 200000; w++) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    bit took;
    int zt;
    for (int r = 0; r < NARCH; r++) m_map[r] = r;
    for (int p = 0; p < NPHYS; p++) begin
      m_cnt[p] = (p < NARCH) ? 1 : 0;
      m_free[p] = (p >= NARCH);
    end
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    check(out_valid == 1'b0, "R11", "out_valid after reset", int'(out_valid), 0);
    check(in_ready == 1'b1, "R1", "ready after reset", int'(in_ready), 1);

    // R1: identity mapping read back through fresh ALU ops
    for (int i = 0; i < 4; i++) send(0, i, 15 - i, 8 + i, 0, "R1", took);
    // R2: read and write the same register
    send(0, 3, 3, 3, 0, "R2", took);
    send(3, 3, 8, 4, 0, "R3", took);
    // R4 then R6: eliminated move and shared reads
    send(1, 2, 0, 5, 1, "R4", took);
    send(0, 5, 2, 9, 0, "R6", took);
    // R5: move without elimination
    send(1, 6, 0, 7, 0, "R5", took);
    // R7: exchange, then read both
    send(2, 1, 0, 7, 0, "R7", took);
    send(0, 1, 7, 10, 0, "R7", took);
    // R10: self move changes nothing
    send(1, 11, 0, 11, 1, "R10", took);
    send(0, 11, 11, 12, 0, "R10", took);
    idle(); idle();
    check(sb.size() == 0, "R11", "pending results", sb.size(), 0);

    // R9: release of a mapped register must not free it
    release_tag(m_map[0]);
    // Drain the pool
    for (int j = 0; model_pick() >= 0 && j < 200; j++)
      send(0, j % NARCH, (j + 3) % NARCH, j % NARCH, 0, "R3", took);
    send(0, 1, 2, 3, 0, "R8", took);
    check(took == 0, "R8", "alloc accepted with empty pool", int'(took), 0);
    send(2, 4, 0, 6, 0, "R8", took);
    check(took == 1, "R8", "exchange refused with empty pool", int'(took), 1);
    send(1, 2, 0, 9, 1, "R8", took);
    check(took == 1, "R8", "eliminated move refused", int'(took), 1);
    release_tag(m_map[2]);
    send(0, 1, 2, 3, 0, "R9", took);
    check(took == 0, "R9", "mapped register was freed", int'(took), 0);
    zt = -1;
    for (int p = NPHYS - 1; p >= 0; p--) if (m_cnt[p] == 0 && !m_free[p]) zt = p;
    release_tag(zt);
    send(0, 1, 2, 3, 0, "R9", took);
    check(took == 1, "R9", "released register not reused", int'(took), 1);
    check(m_map[3] == zt, "R9", "model tag", m_map[3], zt);
    idle(); idle(); idle();
    check(sb.size() == 0, "R11", "pending results at end", sb.size(), 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule